// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the address for a four-beat memory burst. A load cycle captures a full address. The two lowest bits of that address are the burst start point, and the bits above them are the burst base. Each later advance cycle moves the low bits to the next beat. A static mode input chooses between two beat orders. In interleaved order the low bits are the start value XOR the beat count. In linear order the low bits are the start value plus the beat count, modulo four. The upper bits stay as loaded for the whole burst. After the fourth beat the low bits wrap around and never carry into the upper bits.

An active-low clock enable freezes the block completely while it is high: it neither loads nor advances, and its outputs keep their values. The control is a two-state machine. `S_IDLE` is the state after reset, before any burst has been loaded. `S_BURST` is the state while a burst is held. Four transitions exist:
- LOAD moves `S_IDLE` to `S_BURST`.
- RELOAD stays in `S_BURST` and captures a new address.
- STEP stays in `S_BURST` and advances the beat.
- HOLD keeps the current state when the clock enable is inactive.

In `S_IDLE` an advance request has no effect.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `addr_out` is all zeros and `burst_active` is 0.
- R2: At a clock edge where `clk_en_n`=0 and `advance`=0 (load), the block captures `addr_in`. From the next edge onward `addr_out` equals that `addr_in` and `burst_active` is 1.
- R3: With `interleave`=1, after k advances since the load, `addr_out[1:0]` equals start XOR (k mod 4). Start is the loaded `addr_in[1:0]`. For example, a start of 2 gives the sequence 2,3,0,1,2,...
- R4: With `interleave`=0, after k advances since the load, `addr_out[1:0]` equals (start + k) mod 4. For example, a start of 3 gives the sequence 3,0,1,2,3,...
- R5: While a burst advances, `addr_out[ADDR_W-1:2]` keeps the loaded value. Stepping past the fourth beat wraps the low bits and does not carry into the upper bits.
- R6: At an edge where `clk_en_n`=1, `addr_out` and `burst_active` keep their values, whatever `advance` and `addr_in` are.
- R7: An advance (`clk_en_n`=0, `advance`=1) while `burst_active`=0 leaves `addr_out` at zero and `burst_active` at 0.
- R8: A load during a burst restarts the sequence. The new address appears, and the beat count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| advance | input | 1 | 1 = advance the burst, 0 = load `addr_in` |
| interleave | input | 1 | Static order select: 1 = XOR order, 0 = linear wrap order |
| addr_in | input | ADDR_W (18) | Address captured on a load |
| addr_out | output | ADDR_W (18) | Current burst address |
| burst_active | output | 1 | 1 while a burst is held (state `S_BURST`) |

## Verification
Every result of this block is registered and is due exactly one rising edge after the stimulus. A load, a step or a stall shows on `addr_out` and `burst_active` after that single edge, and reset acts at once. The bench changes inputs 1 ns after a rising edge and compares the outputs 1 ns after the next rising edge. Each comparison therefore sees the effect of exactly one sampled command. For each start value in each order, the bench compares every beat over eight advances with a stall in the middle. The stall check is made at the cycle where a wrongly taken load or step would already be visible.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Sequencer control states
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_BURST = 1'b1
    } seq_state_e;

    // Command decoded from the sampled control inputs
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } seq_cmd_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en_n,
    input  logic       advance,
    output seq_state_e state,
    output logic       load_en,
    output logic       step_en
);

    seq_state_e state_d;
    seq_cmd_e   cmd;

    // Command decode from sampled controls
    always_comb begin
        if (clk_en_n)
            cmd = CMD_HOLD;
        else if (!advance)
            cmd = CMD_LOAD;
        else
            cmd = CMD_STEP;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_d;
    end

    // Next state and datapath strobes
    always_comb begin
        state_d = state;
        load_en = 1'b0;
        step_en = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cmd == CMD_LOAD) begin
                    state_d = S_BURST;   // LOAD
                    load_en = 1'b1;
                end
            end
            S_BURST: begin
                if (cmd == CMD_LOAD) begin
                    load_en = 1'b1;      // RELOAD
                end else if (cmd == CMD_STEP) begin
                    step_en = 1'b1;      // STEP
                end
            end
        endcase
    end

endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [BEAT_W-1:0] cnt
);

    // Counts naturally modulo 2**BEAT_W, so the burst wraps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + BEAT_W'(1);
    end

endmodule

// File: rtl/addr_capture.sv
module addr_capture #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic [ADDR_W-BEAT_W-1:0] base_q,
    output logic [BEAT_W-1:0]        start_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= '0;
        end else if (load) begin
            base_q  <= addr_in[ADDR_W-1:BEAT_W];
            start_q <= addr_in[BEAT_W-1:0];
        end
    end

endmodule

// File: rtl/lsb_mapper.sv
module lsb_mapper #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              interleave,
    output logic [BEAT_W-1:0] lsb
);

    logic [BEAT_W-1:0] xor_order;
    logic [BEAT_W-1:0] lin_order;

    // Interleaved order: each bit flips independently
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
        assign xor_order[b] = start[b] ^ beat[b];
    end

    // Linear order: modular add, carry out of the top bit dropped
    assign lin_order = start + beat;

    always_comb begin
        lsb = interleave ? xor_order : lin_order;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              advance,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);

    localparam int BASE_W = ADDR_W - BEAT_W;

    seq_state_e        state;
    logic              load_en;
    logic              step_en;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] start_q;
    logic [BASE_W-1:0] base_q;
    logic [BEAT_W-1:0] lsb;

    burst_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en_n (clk_en_n),
        .advance  (advance),
        .state    (state),
        .load_en  (load_en),
        .step_en  (step_en)
    );

    beat_counter #(.BEAT_W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load_en),
        .inc   (step_en),
        .cnt   (beat)
    );

    addr_capture #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_en),
        .addr_in (addr_in),
        .base_q  (base_q),
        .start_q (start_q)
    );

    lsb_mapper #(.BEAT_W(BEAT_W)) u_map (
        .start      (start_q),
        .beat       (beat),
        .interleave (interleave),
        .lsb        (lsb)
    );

    always_comb begin
        addr_out     = {base_q, lsb};
        burst_active = (state == S_BURST);
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              advance,
    input logic              interleave,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              burst_active
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (addr_out == '0 && !burst_active));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !advance) |=> (addr_out == $past(addr_in) && burst_active));

    // R3
    xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && advance && burst_active && interleave && $stable(interleave))
        |=> (addr_out[0] != $past(addr_out[0])));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && advance && burst_active && !interleave)
        |=> (!interleave -> addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1'b1)));

    // R5
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && advance && burst_active)
        |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(burst_active) && (interleave != $past(interleave) || $stable(addr_out))));

    // R7
    idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && advance && !burst_active) |=> (addr_out == '0 && !burst_active));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en_n;
    logic          advance;
    logic          interleave;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_en_n     (clk_en_n),
        .advance      (advance),
        .interleave   (interleave),
        .addr_in      (addr_in),
        .addr_out     (addr_out),
        .burst_active (burst_active)
    );

    // Vector: {mode, start[1:0], beats} where beat k sits in bits [2k+1:2k]
    localparam logic [10:0] VEC [8] = '{
        {1'b1, 2'd0, 8'hE4},   // xor  : 0 1 2 3
        {1'b1, 2'd1, 8'hB1},   // xor  : 1 0 3 2
        {1'b1, 2'd2, 8'h4E},   // xor  : 2 3 0 1
        {1'b1, 2'd3, 8'h1B},   // xor  : 3 2 1 0
        {1'b0, 2'd0, 8'hE4},   // lin  : 0 1 2 3
        {1'b0, 2'd1, 8'h39},   // lin  : 1 2 3 0
        {1'b0, 2'd2, 8'h4E},   // lin  : 2 3 0 1
        {1'b0, 2'd3, 8'h93}    // lin  : 3 0 1 2
    };

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one command for exactly one rising edge, then settle
    task automatic cycle(input logic en_n, input logic adv, input logic [AW-1:0] a);
        clk_en_n = en_n;
        advance  = adv;
        addr_in  = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n      = 1'b0;
        clk_en_n   = 1'b1;
        advance    = 1'b0;
        interleave = 1'b1;
        addr_in    = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset addr", addr_out, '0);
        check("R1 reset active", AW'(burst_active), '0);
        rst_n = 1'b1;

        // R7: advance before any load does nothing
        cycle(1'b0, 1'b1, 18'h2AAAA);
        check("R7 idle advance addr", addr_out, '0);
        check("R7 idle advance active", AW'(burst_active), '0);

        // R6: stalled load request is ignored
        cycle(1'b1, 1'b0, 18'h15555);
        check("R6 stall in idle addr", addr_out, '0);
        check("R6 stall in idle active", AW'(burst_active), '0);

        // Table walk: every start value in both orders
        for (int i = 0; i < 8; i++) begin
            logic [15:0] base;
            logic [1:0]  st;
            logic [7:0]  seq;
            logic [AW-1:0] hold;
            base = 16'h5A00 + 16'(i * 16'h0123);
            {interleave, st, seq} = VEC[i];
            cycle(1'b0, 1'b0, {base, st});
            check("R2 load capture", addr_out, {base, st});
            check("R2 load active", AW'(burst_active), AW'(1));
            for (int k = 1; k <= 8; k++) begin
                if (k == 3) begin
                    hold = addr_out;
                    cycle(1'b1, 1'b0, ~{base, st});
                    check("R6 stall mid burst", addr_out, hold);
                    cycle(1'b1, 1'b1, 18'h0);
                    check("R6 stall step ignored", addr_out, hold);
                end
                cycle(1'b0, 1'b1, ~{base, st});
                check(interleave ? "R3 R5 xor beat" : "R4 R5 linear beat",
                      addr_out, {base, seq[2*(k%4) +: 2]});
            end
        end

        // R8: reload during a burst restarts the count
        interleave = 1'b0;
        cycle(1'b0, 1'b0, 18'h3FFFE);
        cycle(1'b0, 1'b1, 18'h0);
        check("R4 R5 linear wrap no carry", addr_out, 18'h3FFFF);
        cycle(1'b0, 1'b1, 18'h0);
        check("R5 wrap keeps base", addr_out, 18'h3FFFC);
        cycle(1'b0, 1'b0, 18'h01231);
        check("R8 reload address", addr_out, 18'h01231);
        cycle(1'b0, 1'b1, 18'h0);
        check("R8 reload restarts count", addr_out, 18'h01232);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule